// File: doc/BRIEF.md
# Exhaustive-Service Crossbar Scheduler with Starvation Aging

This block decides, once per clock (one cell slot), which inputs of an N x N virtual-output-queue switch are connected to which outputs. It is fed a flag per input/output queue saying whether that queue holds cells. A connection, once formed, is kept slot after slot until its queue runs dry. New connections are formed in a single round-robin request, grant and accept pass. Only inputs and outputs that were unconnected at the start of the slot take part in that pass.

Long-held connections could shut other queues out of an output. To prevent this, every queue that holds cells and is not being served keeps a saturating wait count. When that count reaches a programmable limit and the queue's input is idle, the output it wants is released at the end of the slot. In the next pass, that output grants aged requests ahead of all others.

Each input is a two-state machine. In `PS_FREE` it takes part in matching. Transition `T_TAKE` (its accept fires) moves it to `PS_SERVE`. In `PS_SERVE`, transition `T_KEEP` holds it while its queue stays non-empty and its output is not evicted. Transition `T_DRAIN` (queue empty) or `T_EVICT` (output pre-empted) returns it to `PS_FREE`.

Top module: `emx_sched`

## Requirements
- R1: Reset, asynchronous and active low, clears every connection: `match_vld` is all zero and every `match_dst` field is zero. It also clears every wait count and round-robin pointer.
- R2: Queue flag for input i and output j is `voq_nonempty[i*N+j]`. The output chosen for input i is `match_dst[i*IW +: IW]`, valid when `match_vld[i]` is 1 and zero otherwise. A connection formed in a slot appears on these ports after that slot's clock edge.
- R3: A connected input keeps the same output, and sends no request, for as long as its queue flag stays high and its output is not pre-empted.
- R4: If the served queue's flag is low in a slot, the connection is gone after that edge. The freed ports may be matched in the following slot.
- R5: A request exists only between an input and an output that are both unconnected at the start of the slot. An idle input whose non-empty queues all target busy outputs stays unconnected.
- R6: Each output grants the first requesting input at or after its grant pointer, wrapping modulo N. After its grant is accepted, the pointer moves to one past the accepted input.
- R7: Each input accepts the first granting output at or after its accept pointer, wrapping modulo N. The pointer then moves to one past the accepted output.
- R8: No two connected inputs ever name the same output.
- R9: Each queue's wait count saturates. It rises by one per slot while the queue is non-empty and unserved. It returns to zero when the queue is empty, served or newly accepted. A queue counts as aged when its count is at least `age_limit`.
- R10: An output that is connected is released after the edge of any slot in which an aged queue targets it from an unconnected input.
- R11: An output grants among aged requests ahead of any non-aged request, whatever its pointer says.
- R12: Among several aged requests, an output picks the one nearest at or after its grant pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voq_nonempty | input | N*N | Queue non-empty flags, bit i*N+j for input i to output j |
| age_limit | input | AGE_W | Wait count at which a queue is aged |
| match_vld | output | N | Input i is connected |
| match_dst | output | N*IW | Output index per input, field i at i*IW |

## Verification
Diagonal traffic with no contention shows that fresh matches form in one slot and hold while queues stay full. Selective draining shows that only the drained pair is torn down, and that freed ports rejoin the pass one slot later. Several inputs contending for one output, and one input receiving two grants, separate pointer-based round-robin from fixed lowest-index priority. A short age limit with one output held shows the exact slot at which the count triggers eviction. It also shows an aged request beating a non-aged one that sits nearer the pointer, and the nearest-to-pointer choice among two aged requests.

// File: rtl/emx_pkg.sv
package emx_pkg;
    typedef enum logic {
        PS_FREE  = 1'b0,
        PS_SERVE = 1'b1
    } port_state_e;
endpackage

// File: rtl/emx_rr_arb.sv
// Round-robin picker with a priority class: if any prioritised request is
// present, only those compete; the first one at or after ptr wins.
module emx_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  pri,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt
);
    logic [N-1:0] pool;
    int           idx;

    always_comb begin
        pool = (|(req & pri)) ? (req & pri) : req;
        gnt  = '0;
        idx  = 0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (pool[idx] && (gnt == '0)) gnt[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/emx_age_ctr.sv
// Saturating wait counter for one queue.
module emx_age_ctr #(
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic             grab,
    input  logic [AGE_W-1:0] limit,
    output logic             aged
);
    logic [AGE_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!pending || grab) cnt <= '0;
        else if (cnt != '1)        cnt <= cnt + 1'b1;
    end

    assign aged = pending && (cnt >= limit);
endmodule

// File: rtl/emx_port_fsm.sv
// Per-input connection state machine.
module emx_port_fsm
    import emx_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [IW-1:0] take_dst,
    input  logic          keep,
    output logic          busy,
    output logic [IW-1:0] dst
);
    port_state_e   st_q, st_d;
    logic [IW-1:0] dst_q, dst_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_FREE;
            dst_q <= '0;
        end else begin
            st_q  <= st_d;
            dst_q <= dst_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        dst_d = dst_q;
        unique case (st_q)
            PS_FREE: begin
                if (take) begin          // T_TAKE
                    st_d  = PS_SERVE;
                    dst_d = take_dst;
                end
            end
            PS_SERVE: begin
                if (!keep) begin         // T_DRAIN or T_EVICT
                    st_d  = PS_FREE;
                    dst_d = '0;
                end                      // else T_KEEP
            end
        endcase
    end

    always_comb begin
        busy = (st_q == PS_SERVE);
        dst  = dst_q;
    end
endmodule

// File: rtl/emx_sched.sv
module emx_sched #(
    parameter int N     = 4,
    parameter int AGE_W = 4,
    parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N*N-1:0]    voq_nonempty,
    input  logic [AGE_W-1:0]  age_limit,
    output logic [N-1:0]      match_vld,
    output logic [N*IW-1:0]   match_dst
);
    logic [N-1:0]   in_busy;
    logic [IW-1:0]  in_dst   [N];
    logic [IW-1:0]  take_dst [N];
    logic [IW-1:0]  gptr     [N];
    logic [IW-1:0]  aptr     [N];
    logic [IW-1:0]  won_src  [N];
    logic [N-1:0]   out_busy, preempt, keep, take, out_won;
    // output-major (j*N+i) and input-major (i*N+j) flattened matrices
    logic [N*N-1:0] req_om, aged_om, gnt_om, gnt_im, acc_im;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            out_busy[j] = 1'b0;
            for (int i = 0; i < N; i++)
                if (in_busy[i] && (in_dst[i] == IW'(j))) out_busy[j] = 1'b1;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        for (genvar j = 0; j < N; j++) begin : g_out
            logic served, pend;
            assign served = in_busy[i] && (in_dst[i] == IW'(j));
            assign pend   = voq_nonempty[i*N+j] && !served;
            emx_age_ctr #(.AGE_W(AGE_W)) u_age (
                .clk     (clk),
                .rst_n   (rst_n),
                .pending (pend),
                .grab    (acc_im[i*N+j]),
                .limit   (age_limit),
                .aged    (aged_om[j*N+i])
            );
            assign req_om[j*N+i] = !in_busy[i] && !out_busy[j] && voq_nonempty[i*N+j];
            assign gnt_im[i*N+j] = gnt_om[j*N+i];
        end

        emx_rr_arb #(.N(N), .IW(IW)) u_acc (
            .req (gnt_im[i*N +: N]),
            .pri ({N{1'b0}}),
            .ptr (aptr[i]),
            .gnt (acc_im[i*N +: N])
        );

        emx_port_fsm #(.IW(IW)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (take[i]),
            .take_dst (take_dst[i]),
            .keep     (keep[i]),
            .busy     (in_busy[i]),
            .dst      (in_dst[i])
        );

        assign match_vld[i]            = in_busy[i];
        assign match_dst[i*IW +: IW]   = in_dst[i];
    end

    for (genvar j = 0; j < N; j++) begin : g_grant
        emx_rr_arb #(.N(N), .IW(IW)) u_gnt (
            .req (req_om[j*N +: N]),
            .pri (aged_om[j*N +: N]),
            .ptr (gptr[j]),
            .gnt (gnt_om[j*N +: N])
        );
    end

    // Eviction of a held output by an aged queue whose input is idle.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            preempt[j] = 1'b0;
            for (int i = 0; i < N; i++)
                if (aged_om[j*N+i] && !in_busy[i]) preempt[j] = out_busy[j];
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            keep[i]     = voq_nonempty[i*N + int'(in_dst[i])] && !preempt[in_dst[i]];
            take[i]     = |acc_im[i*N +: N];
            take_dst[i] = '0;
            for (int j = 0; j < N; j++)
                if (acc_im[i*N+j]) take_dst[i] = IW'(j);
        end
        for (int j = 0; j < N; j++) begin
            out_won[j] = 1'b0;
            won_src[j] = '0;
            for (int i = 0; i < N; i++)
                if (acc_im[i*N+j]) begin
                    out_won[j] = 1'b1;
                    won_src[j] = IW'(i);
                end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                gptr[k] <= '0;
                aptr[k] <= '0;
            end
        end else begin
            for (int k = 0; k < N; k++) begin
                if (out_won[k])
                    gptr[k] <= (won_src[k] == IW'(N-1)) ? '0 : won_src[k] + 1'b1;
                if (take[k])
                    aptr[k] <= (take_dst[k] == IW'(N-1)) ? '0 : take_dst[k] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/emx_sched_chk.sv
module emx_sched_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N*N-1:0]  voq_nonempty,
    input logic [N-1:0]    match_vld,
    input logic [N*IW-1:0] match_dst,
    input logic [N-1:0]    preempt
);
    logic [N*N-1:0] voq_q;
    logic [IW-1:0]  d [N];
    logic [N-1:0]   occ;

    always_ff @(posedge clk) voq_q <= voq_nonempty;

    for (genvar i = 0; i < N; i++) begin : g_d
        assign d[i] = match_dst[i*IW +: IW];
    end

    always_comb begin
        for (int j = 0; j < N; j++) begin
            occ[j] = 1'b0;
            for (int i = 0; i < N; i++)
                if (match_vld[i] && (d[i] == IW'(j))) occ[j] = 1'b1;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_a
        a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !match_vld[i] |-> (d[i] == '0));
        a_r2_needs_queue: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(match_vld[i]) |-> voq_q[i*N + int'(d[i])]);
        a_r3_dst_stable: assert property (@(posedge clk) disable iff (!rst_n)
            match_vld[i] |=> (!match_vld[i] || (d[i] == $past(d[i]))));
        a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
            (match_vld[i] && !voq_nonempty[i*N + int'(d[i])]) |=> !match_vld[i]);
        for (genvar k = i + 1; k < N; k++) begin : g_pair
            a_r8_unique_out: assert property (@(posedge clk) disable iff (!rst_n)
                !(match_vld[i] && match_vld[k] && (d[i] == d[k])));
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_o
        a_r10_evict: assert property (@(posedge clk) disable iff (!rst_n)
            preempt[j] |=> !occ[j]);
    end
endmodule

bind emx_sched emx_sched_chk #(.N(N), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .voq_nonempty (voq_nonempty),
    .match_vld    (match_vld),
    .match_dst    (match_dst),
    .preempt      (preempt)
);

// File: tb/emx_sched_tb.sv
`timescale 1ns/1ps
module emx_sched_tb;
    localparam int N = 4;
    localparam int AGE_W = 4;
    localparam int IW = 2;
    localparam int NV = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N*N-1:0]    voq = '0;
    logic [AGE_W-1:0]  lim = 4'd15;
    logic [N-1:0]      vld;
    logic [N*IW-1:0]   dst;
    int                n_chk = 0;
    int                n_bad = 0;
    int                cyc = 0;

    always #2 clk = ~clk;

    emx_sched #(.N(N), .AGE_W(AGE_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .voq_nonempty (voq),
        .age_limit    (lim),
        .match_vld    (vld),
        .match_dst    (dst)
    );

    // Vector table: queue flags, expected valid mask, expected dst fields.
    // v1 R2 fresh diagonal; v2 R3 hold; v3 R4 drain; v4 R5 rematch;
    // v5 R4 multi-drain; v6 R6 contention; v7 R5 blocked; v8 R4; v9 R6;
    // v10 R4; v11 R7 two grants to one input.
    localparam logic [15:0] T_VOQ [NV] = '{16'h8421, 16'h8423, 16'h8403, 16'h8463,
        16'h8142, 16'h8226, 16'h8226, 16'h8026, 16'h8026, 16'h8040, 16'h8060};
    localparam logic [3:0]  T_VLD [NV] = '{4'hF, 4'hF, 4'hD, 4'hF, 4'h8, 4'hD,
        4'hD, 4'h9, 4'hB, 4'h8, 4'hA};
    localparam logic [7:0]  T_DST [NV] = '{8'hE4, 8'hE4, 8'hE0, 8'hE4, 8'hC0,
        8'hD2, 8'hD2, 8'hC2, 8'hC6, 8'hC0, 8'hC8};
    localparam int          T_REQ [NV] = '{2, 3, 4, 5, 4, 6, 5, 4, 6, 4, 7};

    task automatic check(input logic [3:0] ev, input logic [7:0] ed, input int r);
        n_chk++;
        if (vld !== ev || dst !== ed) begin
            n_bad++;
            $display("FAIL R%0d: vld=%h dst=%h expected vld=%h dst=%h", r, vld, dst, ev, ed);
        end
    endtask

    task automatic step(input logic [15:0] v);
        voq = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(4'h0, 8'h00, 1);           // R1 during reset
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            step(T_VOQ[k]);
            check(T_VLD[k], T_DST[k], T_REQ[k]);
        end

        // R1: reset mid-run clears every pairing
        rst_n = 1'b0;
        voq = '0;
        @(negedge clk);
        check(4'h0, 8'h00, 1);
        lim = 4'd2;
        rst_n = 1'b1;

        // Aging with limit 2
        step(16'h0001); check(4'h1, 8'h00, 2);
        step(16'h0101); check(4'h1, 8'h00, 9);   // R9 count 0 -> 1
        step(16'h0101); check(4'h1, 8'h00, 9);   // R9 count 1, not yet aged
        step(16'h0101); check(4'h0, 8'h00, 10);  // R10 eviction
        step(16'h0111); check(4'h4, 8'h00, 11);  // R11 aged input 2 beats pointer at 1
        step(16'h0111); check(4'h4, 8'h00, 9);   // R9 fresh counts below limit
        step(16'h0111); check(4'h0, 8'h00, 10);  // R10 eviction again
        step(16'h0111); check(4'h1, 8'h00, 12);  // R12 aged nearest pointer 3

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule